// File: doc/BRIEF.md
# Display Auxiliary-Channel Request Framer

This block turns one auxiliary-channel request into the byte stream that a channel engine sends on the wire. It also turns the engine's completion status back into a result for the requester. The requester gives a start pulse, a 4-bit request code, a 20-bit target address, a payload length and up to 16 payload bytes. The block checks the request, builds a four-byte header, and sends the header, then any write payload, one byte at a time over a valid/ready stream. It then waits for a single completion beat from the engine.

The completion beat carries a status byte and a received-byte count. The status byte either reports a failure or carries the sink's reply in its upper nibble. The block reports a result code, a byte count and the reply nibble, and marks the end of the transaction with a one-cycle done pulse. Only one transaction can be in flight at a time. A request that is too long, or that uses an unsupported code, completes at once with an error and sends no bytes.

Top module: `auxreq_framer`

## Requirements
- R1: Header byte 0 is address bits [7:0] and header byte 1 is address bits [15:8]. Byte 0 is sent first.
- R2: Header byte 2 holds the request code in bits [7:4] and address bits [19:16] in bits [3:0].
- R3: Bits [3:0] of header byte 3 hold the length minus one, or 0 when the length is zero.
- R4: Bits [7:4] of header byte 3 hold the send size, as follows:
  - 3 for any zero-length request;
  - 4 for a read;
  - (4 + length) modulo 16 for a write.
- R5: The block sends the following bytes, and `tx_len_o` equals the number sent:
  - a non-empty write sends the header, then payload bytes 0 to length-1, where byte k is `payload_i[8k+7:8k]`;
  - a read or a zero-length request sends only the four header bytes.
- R6: A length above 16 gives result code 4 (too large) with `result_err_o` high. No bytes are sent. The size check takes priority over the code check.
- R7: The request code is examined with bit 2 (the middle-of-transaction flag) masked off.
  - 0 is an I2C write, 1 is an I2C read, 8 is a native write and 9 is a native read.
  - Any other masked value gives result code 5 (bad request) and sends no bytes.
- R8: A completion status byte equal to 1, 2 or 3 gives result code 1 (timeout), 2 (flags set) or 3 (link error) respectively. In each case `result_err_o` is high, and the count and the reply are 0.
- R9: Any other status byte gives result code 0, and the reply is status bits [7:4].
  - A write reports its length as the count.
  - A read reports the smaller of `cpl_count_i` and the requested length.
- R10: The outputs follow these timing rules:
  - `busy_o` is high from the cycle after an accepted start until completion, and `start_i` is ignored while busy;
  - `done_o` pulses for one cycle, in the cycle after the completion beat is taken, or in the cycle after a rejected start.
- R11: A stream byte advances only on a cycle where `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold.
- R12: After reset, `busy_o`, `tx_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request start pulse |
| req_code_i | input | 4 | Request code (bit 2 = middle-of-transaction flag) |
| addr_i | input | 20 | Target address |
| len_i | input | 5 | Payload length in bytes |
| payload_i | input | 128 | Write payload; byte k in bits [8k+7:8k] |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream byte accepted by the engine |
| tx_len_o | output | 5 | Number of bytes in the current stream |
| cpl_valid_i | input | 1 | Completion beat from the engine |
| cpl_status_i | input | 8 | Completion status / acknowledge byte |
| cpl_count_i | input | 5 | Bytes received by the engine |
| busy_o | output | 1 | Transaction in flight |
| done_o | output | 1 | One-cycle completion pulse |
| result_err_o | output | 1 | Result is an error |
| result_code_o | output | 3 | Result code (0 ok, 1 timeout, 2 flags, 3 link error, 4 too large, 5 bad request) |
| result_count_o | output | 5 | Reported byte count |
| reply_o | output | 4 | Reply nibble from the acknowledge byte |

## Verification
The bench drives the following request patterns:
- native and I2C writes and reads, at mid-range lengths and at lengths 0, 12 and 16, with addresses whose top nibble is non-zero;
- a write of length 12, whose send size wraps the nibble to zero, which shows whether the size field is truncated rather than saturated;
- a zero-length read and a zero-length write, which separate the bare-address code from the read and write size codes.

The completion side is driven with the following:
- each of the three failure statuses;
- success statuses with non-zero upper nibbles;
- read counts above and below the request, which exposes the clipping rule.

The stream is checked both with ready held high and with ready stalled on alternate cycles. One run pulses a bad start mid-stream to show that the in-flight frame is not disturbed.

// File: rtl/auxreq_pkg.sv
package auxreq_pkg;

  localparam int HDR_BYTES = 4;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_TIMEOUT = 3'd1,
    RES_FLAGS   = 3'd2,
    RES_LINKERR = 3'd3,
    RES_TOOBIG  = 3'd4,
    RES_BADREQ  = 3'd5
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } st_e;

  // Request code with the middle-of-transaction flag removed.
  function automatic logic [3:0] strip_mot(input logic [3:0] code);
    return code & 4'hB;
  endfunction

  function automatic logic code_known(input logic [3:0] code);
    logic [3:0] m;
    m = strip_mot(code);
    return (m == 4'h0) || (m == 4'h1) || (m == 4'h8) || (m == 4'h9);
  endfunction

  // Fourth header byte: send size nibble over length nibble.
  function automatic logic [7:0] size_byte(input logic [7:0] len, input logic rd);
    logic [7:0] total;
    logic [3:0] hi;
    logic [3:0] lo;
    total = 8'(HDR_BYTES) + len;
    if (len == 8'd0) begin
      hi = 4'd3;
      lo = 4'd0;
    end else begin
      hi = rd ? 4'(HDR_BYTES) : total[3:0];
      lo = 4'(len - 8'd1);
    end
    return {hi, lo};
  endfunction

  // Number of bytes put on the stream.
  function automatic logic [7:0] stream_len(input logic [7:0] len, input logic rd);
    return rd ? 8'(HDR_BYTES) : 8'(HDR_BYTES) + len;
  endfunction

  function automatic logic [7:0] clip_count(input logic [7:0] got, input logic [7:0] asked);
    return (got > asked) ? asked : got;
  endfunction

endpackage

// File: rtl/auxreq_classify.sv
module auxreq_classify
  import auxreq_pkg::*;
#(
  parameter int MAX_PAY = 16,
  parameter int LEN_W   = 5
) (
  input  logic [3:0]       code_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             is_read_o,
  output res_e             res_o
);

  logic too_big;
  logic known;

  assign too_big   = (int'(len_i) > MAX_PAY);
  assign known     = code_known(code_i);
  assign is_read_o = strip_mot(code_i) == 4'h1 || strip_mot(code_i) == 4'h9;

  always_comb begin
    if (too_big)     res_o = RES_TOOBIG;
    else if (!known) res_o = RES_BADREQ;
    else             res_o = RES_OK;
  end

endmodule

// File: rtl/auxreq_frame.sv
module auxreq_frame
  import auxreq_pkg::*;
#(
  parameter  int MAX_PAY = 16,
  parameter  int LEN_W   = 5,
  localparam int FRAME   = MAX_PAY + HDR_BYTES,
  localparam int TXL_W   = $clog2(FRAME + 1)
) (
  input  logic [3:0]               code_i,
  input  logic [19:0]              addr_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic                     is_read_i,
  input  logic [MAX_PAY*8-1:0]     payload_i,
  output logic [FRAME-1:0][7:0]    frame_o,
  output logic [TXL_W-1:0]         tx_len_o
);

  logic [7:0] len8;
  logic       bare;

  assign len8 = 8'(len_i);
  assign bare = (len_i == '0);

  genvar g;
  generate
    for (g = 0; g < FRAME; g++) begin : g_byte
      if (g == 0) begin : g_a0
        assign frame_o[g] = addr_i[7:0];
      end else if (g == 1) begin : g_a1
        assign frame_o[g] = addr_i[15:8];
      end else if (g == 2) begin : g_a2
        assign frame_o[g] = {code_i, addr_i[19:16]};
      end else if (g == 3) begin : g_sz
        assign frame_o[g] = size_byte(len8, is_read_i);
      end else begin : g_pay
        assign frame_o[g] = payload_i[(g-HDR_BYTES)*8 +: 8];
      end
    end
  endgenerate

  assign tx_len_o = TXL_W'(stream_len(len8, is_read_i || bare));

endmodule

// File: rtl/auxreq_status.sv
module auxreq_status
  import auxreq_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [7:0]       status_i,
  input  logic [LEN_W-1:0] cnt_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             is_read_i,
  output res_e             res_o,
  output logic [LEN_W-1:0] count_o,
  output logic [3:0]       reply_o
);

  always_comb begin
    unique case (status_i)
      8'd1:    res_o = RES_TIMEOUT;
      8'd2:    res_o = RES_FLAGS;
      8'd3:    res_o = RES_LINKERR;
      default: res_o = RES_OK;
    endcase
  end

  always_comb begin
    if (res_o != RES_OK) begin
      count_o = '0;
      reply_o = 4'd0;
    end else begin
      count_o = is_read_i ? LEN_W'(clip_count(8'(cnt_i), 8'(len_i))) : len_i;
      reply_o = status_i[7:4];
    end
  end

endmodule

// File: rtl/auxreq_framer.sv
module auxreq_framer
  import auxreq_pkg::*;
#(
  parameter  int MAX_PAY = 16,
  localparam int LEN_W   = $clog2(MAX_PAY + 1),
  localparam int FRAME   = MAX_PAY + HDR_BYTES,
  localparam int TXL_W   = $clog2(FRAME + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [3:0]           req_code_i,
  input  logic [19:0]          addr_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [MAX_PAY*8-1:0] payload_i,
  output logic [7:0]           tx_data_o,
  output logic                 tx_valid_o,
  input  logic                 tx_ready_i,
  output logic [TXL_W-1:0]     tx_len_o,
  input  logic                 cpl_valid_i,
  input  logic [7:0]           cpl_status_i,
  input  logic [LEN_W-1:0]     cpl_count_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 result_err_o,
  output logic [2:0]           result_code_o,
  output logic [LEN_W-1:0]     result_count_o,
  output logic [3:0]           reply_o
);

  // Front-end decode
  logic                   cls_read;
  res_e                   cls_res;
  logic [FRAME-1:0][7:0]  frame_w;
  logic [TXL_W-1:0]       txlen_w;

  auxreq_classify #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u_cls (
    .code_i    (req_code_i),
    .len_i     (len_i),
    .is_read_o (cls_read),
    .res_o     (cls_res)
  );

  auxreq_frame #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u_frm (
    .code_i    (req_code_i),
    .addr_i    (addr_i),
    .len_i     (len_i),
    .is_read_i (cls_read),
    .payload_i (payload_i),
    .frame_o   (frame_w),
    .tx_len_o  (txlen_w)
  );

  // State
  st_e                    state_q;
  logic [FRAME-1:0][7:0]  frame_q;
  logic [TXL_W-1:0]       txlen_q;
  logic [TXL_W-1:0]       idx_q;
  logic [LEN_W-1:0]       len_q;
  logic                   rd_q;
  logic                   done_q;
  res_e                   res_q;
  logic [LEN_W-1:0]       cnt_q;
  logic [3:0]             reply_q;

  // Completion decode
  res_e                   st_res;
  logic [LEN_W-1:0]       st_cnt;
  logic [3:0]             st_reply;

  auxreq_status #(.LEN_W(LEN_W)) u_sts (
    .status_i  (cpl_status_i),
    .cnt_i     (cpl_count_i),
    .len_i     (len_q),
    .is_read_i (rd_q),
    .res_o     (st_res),
    .count_o   (st_cnt),
    .reply_o   (st_reply)
  );

  // Named events for the assertions
  logic start_acc;
  logic start_bad;
  logic byte_fire;
  logic frame_last;
  logic cpl_take;

  assign start_acc  = (state_q == ST_IDLE) && start_i;
  assign start_bad  = start_acc && (cls_res != RES_OK);
  assign byte_fire  = tx_valid_o && tx_ready_i;
  assign frame_last = (idx_q == txlen_q - TXL_W'(1));
  assign cpl_take   = (state_q == ST_WAIT) && cpl_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
      txlen_q <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
      cnt_q   <= '0;
      reply_q <= 4'd0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            len_q <= len_i;
            rd_q  <= cls_read;
            if (cls_res != RES_OK) begin
              done_q  <= 1'b1;
              res_q   <= cls_res;
              cnt_q   <= '0;
              reply_q <= 4'd0;
            end else begin
              state_q <= ST_SEND;
              frame_q <= frame_w;
              txlen_q <= txlen_w;
              idx_q   <= '0;
            end
          end
        end
        ST_SEND: begin
          if (byte_fire) begin
            if (frame_last) state_q <= ST_WAIT;
            else            idx_q   <= idx_q + TXL_W'(1);
          end
        end
        ST_WAIT: begin
          if (cpl_valid_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= st_res;
            cnt_q   <= st_cnt;
            reply_q <= st_reply;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid_o     = (state_q == ST_SEND);
  assign tx_data_o      = frame_q[idx_q];
  assign tx_len_o       = txlen_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = done_q;
  assign result_code_o  = res_q;
  assign result_err_o   = (res_q != RES_OK);
  assign result_count_o = cnt_q;
  assign reply_o        = reply_q;

  // Assertions
  p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_len_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(tx_len_o));

  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (done_o && !busy_o && !tx_valid_o && result_err_o));

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_err_o) |-> (result_count_o == '0 && reply_o == 4'd0));

  p_clip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !result_err_o && rd_q) |-> (result_count_o <= len_q));

  p_done_after_cpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_take |=> (done_o && !busy_o));

endmodule

// File: tb/sim_auxreq_framer.sv
module sim_auxreq_framer;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [3:0]   req_code_i = '0;
  logic [19:0]  addr_i = '0;
  logic [4:0]   len_i = '0;
  logic [127:0] payload_i = '0;
  logic [7:0]   tx_data_o;
  logic         tx_valid_o;
  logic         tx_ready_i = 1'b0;
  logic [4:0]   tx_len_o;
  logic         cpl_valid_i = 1'b0;
  logic [7:0]   cpl_status_i = '0;
  logic [4:0]   cpl_count_i = '0;
  logic         busy_o, done_o, result_err_o;
  logic [2:0]   result_code_o;
  logic [4:0]   result_count_o;
  logic [3:0]   reply_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  auxreq_framer u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scenario runner with its own checks.
  task automatic run_txn(input logic [3:0] code, input logic [19:0] addr, input logic [4:0] len,
                         input logic [7:0] seed, input logic [7:0] st, input logic [4:0] cnt,
                         input bit stall, input bit poke);
    logic [7:0] exp_b [0:19];
    logic [7:0] got [0:31];
    int  exp_n, ng, ndone, got_len, exp_res, exp_cnt, exp_rep;
    bit  seen_len, poked, rd, known, zero;
    logic [3:0] m;
    for (int k = 0; k < 16; k++) payload_i[8*k +: 8] = seed + 8'(7 * k);
    m     = code & 4'hB;
    known = (m == 4'h0) || (m == 4'h1) || (m == 4'h8) || (m == 4'h9);
    rd    = m[0];
    zero  = (len == 0);
    exp_b[0] = addr[7:0];
    exp_b[1] = addr[15:8];
    exp_b[2] = {code, addr[19:16]};
    if (zero)     exp_b[3] = 8'h30;
    else if (rd)  exp_b[3] = {4'h4, 4'(len - 1)};
    else          exp_b[3] = {4'(len + 4), 4'(len - 1)};
    for (int k = 0; k < 16; k++) exp_b[4 + k] = payload_i[8*k +: 8];
    exp_n = (rd || zero) ? 4 : 4 + int'(len);
    if (len > 16)      exp_res = 4;
    else if (!known)   exp_res = 5;
    else if (st >= 1 && st <= 3) exp_res = int'(st);
    else               exp_res = 0;
    if (exp_res >= 4) exp_n = 0;
    exp_cnt = (exp_res != 0) ? 0 : rd ? ((cnt > len) ? int'(len) : int'(cnt)) : int'(len);
    exp_rep = (exp_res != 0) ? 0 : int'(st[7:4]);

    @(negedge clk);
    start_i = 1'b1; req_code_i = code; addr_i = addr; len_i = len;
    cpl_status_i = st; cpl_count_i = cnt;
    ng = 0; ndone = 0; seen_len = 0; poked = 0; got_len = 0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      start_i = 1'b0; tx_ready_i = 1'b0; cpl_valid_i = 1'b0;
      if (done_o) begin ndone++; break; end
      if (tx_valid_o) begin
        if (!seen_len) begin got_len = int'(tx_len_o); seen_len = 1; end
        if (poke && !poked) begin
          start_i = 1'b1; req_code_i = 4'h2; len_i = 5'd20; addr_i = 20'hFFFFF; poked = 1;
        end
        if (!stall || (cyc % 2 == 1)) begin
          tx_ready_i = 1'b1;
          if (ng < 32) got[ng] = tx_data_o;
          ng++;
        end
      end else if (busy_o) begin
        cpl_valid_i = 1'b1;
      end
    end
    chk(ndone == 1, "R10 done pulse seen", ndone, 1);
    chk(ng == exp_n, "R5 stream byte count", ng, exp_n);
    if (exp_n > 0 && ng == exp_n) begin
      chk(got_len == exp_n, "R5 tx_len_o", got_len, exp_n);
      chk({got[1], got[0]} == {exp_b[1], exp_b[0]}, "R1 address low bytes",
          int'({got[1], got[0]}), int'({exp_b[1], exp_b[0]}));
      chk(got[2] == exp_b[2], "R2 code/address byte", got[2], exp_b[2]);
      chk(got[3][3:0] == exp_b[3][3:0], "R3 length nibble", got[3][3:0], exp_b[3][3:0]);
      chk(got[3][7:4] == exp_b[3][7:4], "R4 size nibble", got[3][7:4], exp_b[3][7:4]);
      for (int k = 4; k < exp_n; k++)
        chk(got[k] == exp_b[k], "R5 payload byte", got[k], exp_b[k]);
    end
    chk(int'(result_code_o) == exp_res, "R6 R7 R8 R9 result code", result_code_o, exp_res);
    chk(result_err_o == (exp_res != 0), "R8 error flag", result_err_o, exp_res != 0);
    chk(int'(result_count_o) == exp_cnt, "R9 count", result_count_o, exp_cnt);
    chk(int'(reply_o) == exp_rep, "R9 reply", reply_o, exp_rep);
    @(negedge clk);
    chk(!done_o && !busy_o, "R10 single done and idle", {done_o, busy_o}, 0);
  endtask

  task automatic t_reset;
    chk(!busy_o && !tx_valid_o && !done_o, "R12 reset state", {busy_o, tx_valid_o, done_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_txn(4'h8, 20'h5A3C1, 5'd3,  8'h11, 8'h00, 5'd0,  0, 0); // native write
    run_txn(4'h1, 20'hB1234, 5'd16, 8'h20, 8'h20, 5'd20, 0, 0); // I2C read clipped
    run_txn(4'h9, 20'h0F00F, 5'd5,  8'h30, 8'h50, 5'd3,  1, 0); // native read short
    run_txn(4'h4, 20'h00077, 5'd0,  8'h40, 8'h00, 5'd0,  0, 0); // zero-length MOT write
    run_txn(4'h9, 20'h12345, 5'd0,  8'h44, 8'h10, 5'd0,  0, 0); // zero-length read
    run_txn(4'h0, 20'hC0DE5, 5'd12, 8'h50, 8'h00, 5'd0,  1, 0); // size nibble wraps
    run_txn(4'hC, 20'hFEDCB, 5'd16, 8'h60, 8'h80, 5'd0,  1, 0); // full write with stalls
    run_txn(4'h2, 20'h00001, 5'd17, 8'h00, 8'h00, 5'd0,  0, 0); // oversize wins
    run_txn(4'h2, 20'h00001, 5'd1,  8'h00, 8'h00, 5'd0,  0, 0); // bad code
    run_txn(4'hA, 20'h00001, 5'd1,  8'h00, 8'h00, 5'd0,  0, 0); // bad code
    run_txn(4'hD, 20'h44444, 5'd2,  8'h70, 8'h30, 5'd9,  0, 0); // MOT native read
    run_txn(4'h8, 20'h00100, 5'd2,  8'h80, 8'h01, 5'd0,  0, 0); // timeout
    run_txn(4'h1, 20'h00200, 5'd2,  8'h90, 8'h02, 5'd2,  0, 0); // flags
    run_txn(4'h0, 20'h00300, 5'd2,  8'hA0, 8'h03, 5'd0,  0, 0); // link error
    run_txn(4'h8, 20'h9ABCD, 5'd4,  8'hB0, 8'hF0, 5'd0,  1, 1); // R10 start while busy
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule